// File: doc/BRIEF.md
# Hamming-Matrix Concurrent Error Checker

This block watches a combinational function that has NOUT outputs and reports on each clock whether those outputs agree with a check vector. That check vector is predicted separately from the function's primary inputs. The block rebuilds NCHK check bits from the observed outputs with a generating matrix of Hamming type. It then compares them with the predicted vector and reports the result on a two-rail indication pair. It only detects errors. It never tries to repair a word, because a mismatch does not show which word was meant.

The generating matrix is built at elaboration. Its candidate rows are every NCHK-bit word that holds at least two ones. They are listed in ascending binary order and numbered from 1. The odd-numbered candidates are placed first and the even-numbered ones after them, and output i takes the i-th row of that order. The function usually has fewer outputs than there are candidates, which shortens the code. The scattered order keeps every check bit tied to at least one output. Elaboration stops if NOUT exceeds 2^NCHK − NCHK − 1.

The rebuilt bit and the inverted predicted bit form one two-rail pair for each check position. A chain of two-rail combining cells reduces these pairs to a single pair, and that pair is registered.

Top module: `hmx_ced_checker`

## Requirements
- R1: While `rst` is high at a rising edge, `ind` becomes 2'b01 whatever the other inputs are.
- R2: `ind` is registered. It reflects `func_out` and `pred_chk` as sampled at the previous rising edge, and it stays unchanged between edges and while those inputs are held.
- R3: Rebuilt check bit k is the XOR of every output bit whose matrix row has bit k set. With the defaults (NOUT=7, NCHK=4), the rows for outputs 0 to 6 are 0x3, 0x6, 0x9, 0xB, 0xD, 0xF and 0x5.
- R4: When `pred_chk` equals the rebuilt check vector, `ind` is a complementary pair, 2'b01 or 2'b10.
- R5: When `pred_chk` differs from the rebuilt check vector in any bit, `ind` is 2'b00 or 2'b11.
- R6: Flipping any single output bit while `pred_chk` is held always yields 2'b00 or 2'b11.
- R7: Flipping any single bit of `pred_chk` while `func_out` is held always yields 2'b00 or 2'b11.
- R8: Flipping any two output bits while `pred_chk` is held always yields 2'b00 or 2'b11.
- R9: With NCHK=4 and a matching check vector, `ind` is 2'b10 when the rebuilt vector has an even number of ones and 2'b01 when it has an odd number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| func_out | input | NOUT | Outputs of the monitored function |
| pred_chk | input | NCHK | Check vector predicted from the primary inputs |
| ind | output | 2 | Two-rail indication: 01/10 correct, 00/11 error |

## Verification
Every result is due exactly one rising edge after its inputs are applied, because the only state is the output register. The bench drives a vector on a falling edge and compares `ind` with its model at the next falling edge. That instant lies after the one capturing edge and before the following one. One test also reads `ind` shortly after a new mismatching vector has been driven, before any edge, to show that the indication has not yet moved. The flip assertions compare the indication with inputs from two edges back, and they only start once three edges have passed since reset.

// File: rtl/hmx_pkg.sv
package hmx_pkg;

  // Number of usable matrix rows: all words of weight two or more.
  function automatic int cand_count(input int nchk);
    return (1 << nchk) - nchk - 1;
  endfunction

  // Row word for position idx (0-based) in the scattered order:
  // odd-numbered candidates first, then even-numbered ones.
  function automatic int scatter_row(input int nchk, input int idx);
    int total;
    int odd_cnt;
    int want;
    int seen;
    int res;
    total   = cand_count(nchk);
    odd_cnt = (total + 1) / 2;
    want    = (idx < odd_cnt) ? (2 * idx + 1) : (2 * (idx - odd_cnt) + 2);
    seen    = 0;
    res     = 0;
    for (int w = 0; w < (1 << nchk); w++) begin
      if ($countones(w) >= 2) begin
        seen = seen + 1;
        if (seen == want) res = w;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/hmx_check_gen.sv
module hmx_check_gen #(
  parameter int NOUT = 7,
  parameter int NCHK = 4
) (
  input  logic [NOUT-1:0] func_out,
  output logic [NCHK-1:0] regen
);

  for (genvar k = 0; k < NCHK; k++) begin : g_bit
    logic [NOUT-1:0] col;
    for (genvar i = 0; i < NOUT; i++) begin : g_row
      localparam int RW = hmx_pkg::scatter_row(NCHK, i);
      assign col[i] = RW[k];
    end
    assign regen[k] = ^(func_out & col);
  end

endmodule

// File: rtl/hmx_rail_cell.sv
module hmx_rail_cell (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [1:0] z
);

  assign z[1] = (a[1] & b[1]) | (a[0] & b[0]);
  assign z[0] = (a[1] & b[0]) | (a[0] & b[1]);

endmodule

// File: rtl/hmx_rail_chain.sv
module hmx_rail_chain #(
  parameter int NPAIR = 4
) (
  input  logic [2*NPAIR-1:0] pairs,
  output logic [1:0]         z
);

  logic [2*NPAIR-1:0] acc;

  assign acc[1:0] = pairs[1:0];

  for (genvar k = 1; k < NPAIR; k++) begin : g_stage
    hmx_rail_cell u_cell (
      .a (acc[2*k-1:2*k-2]),
      .b (pairs[2*k+1:2*k]),
      .z (acc[2*k+1:2*k])
    );
  end

  assign z = acc[2*NPAIR-1:2*NPAIR-2];

endmodule

// File: rtl/hmx_ced_checker.sv
module hmx_ced_checker #(
  parameter int NOUT = 7,
  parameter int NCHK = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NOUT-1:0] func_out,
  input  logic [NCHK-1:0] pred_chk,
  output logic [1:0]      ind
);

  localparam int MAXOUT = hmx_pkg::cand_count(NCHK);

  if (NOUT > MAXOUT || NOUT < 1) begin : g_bad_size
    $error("hmx_ced_checker: NOUT does not fit the available matrix rows");
  end

  logic [NCHK-1:0]   regen;
  logic [2*NCHK-1:0] pairs;
  logic [1:0]        ind_next;

  hmx_check_gen #(.NOUT(NOUT), .NCHK(NCHK)) u_gen (
    .func_out (func_out),
    .regen    (regen)
  );

  for (genvar k = 0; k < NCHK; k++) begin : g_pair
    assign pairs[2*k+1] = regen[k];
    assign pairs[2*k]   = ~pred_chk[k];
  end

  hmx_rail_chain #(.NPAIR(NCHK)) u_chain (
    .pairs (pairs),
    .z     (ind_next)
  );

  always_ff @(posedge clk) begin
    if (rst) ind <= 2'b01;
    else     ind <= ind_next;
  end

endmodule

// File: rtl/hmx_ced_checker_sva.sv
module hmx_ced_checker_sva #(
  parameter int NOUT = 7,
  parameter int NCHK = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NOUT-1:0] func_out,
  input logic [NCHK-1:0] pred_chk,
  input logic [1:0]      ind
);

  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst)               age <= 2'd0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  // R1: first cycle out of reset shows the reset code word
  p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ind == 2'b01));

  // R2: held inputs keep the indication unchanged
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(func_out) == $past(func_out, 2) &&
     $past(pred_chk) == $past(pred_chk, 2)) |-> (ind == $past(ind)));

  // R6: one output flip after a clean word is flagged
  p_out_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(pred_chk) == $past(pred_chk, 2) &&
     $countones($past(func_out) ^ $past(func_out, 2)) == 1 &&
     ($past(ind) == 2'b01 || $past(ind) == 2'b10))
    |-> (ind == 2'b00 || ind == 2'b11));

  // R7: one predicted-bit flip after a clean word is flagged
  p_pred_flip_r7: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(func_out) == $past(func_out, 2) &&
     $countones($past(pred_chk) ^ $past(pred_chk, 2)) == 1 &&
     ($past(ind) == 2'b01 || $past(ind) == 2'b10))
    |-> (ind == 2'b00 || ind == 2'b11));

  // R8: two output flips after a clean word are flagged
  p_dbl_flip_r8: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(pred_chk) == $past(pred_chk, 2) &&
     $countones($past(func_out) ^ $past(func_out, 2)) == 2 &&
     ($past(ind) == 2'b01 || $past(ind) == 2'b10))
    |-> (ind == 2'b00 || ind == 2'b11));

endmodule

bind hmx_ced_checker hmx_ced_checker_sva #(.NOUT(NOUT), .NCHK(NCHK)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .func_out (func_out),
  .pred_chk (pred_chk),
  .ind      (ind)
);

// File: tb/hmx_ced_checker_test.sv
module hmx_ced_checker_test;

  localparam int NOUT = 7;
  localparam int NCHK = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic [NOUT-1:0] func_out;
  logic [NCHK-1:0] pred_chk;
  logic [1:0]      ind;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  int rows[$];

  always #5 clk = ~clk;

  hmx_ced_checker #(.NOUT(NOUT), .NCHK(NCHK)) uut (
    .clk      (clk),
    .rst      (rst),
    .func_out (func_out),
    .pred_chk (pred_chk),
    .ind      (ind)
  );

  // Behavioural matrix: list weight>=2 words, then odd positions, then even
  function automatic void build_rows();
    int cand[$];
    for (int w = 0; w < (1 << NCHK); w++)
      if ($countones(w) >= 2) cand.push_back(w);
    for (int j = 0; j < cand.size(); j += 2) rows.push_back(cand[j]);
    for (int j = 1; j < cand.size(); j += 2) rows.push_back(cand[j]);
  endfunction

  function automatic logic [NCHK-1:0] model_gen(input logic [NOUT-1:0] fo);
    logic [NCHK-1:0] g = '0;
    for (int i = 0; i < NOUT; i++)
      if (fo[i]) g = g ^ NCHK'(rows[i]);
    return g;
  endfunction

  task automatic note(input bit ok, input string req, input logic [1:0] act,
                      input string expstr);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: ind=%b expected %s", req, act, expstr);
    end
  endtask

  // Called at a falling edge: drive, wait one edge, compare at next falling edge
  task automatic step(input logic [NOUT-1:0] fo, input logic [NCHK-1:0] pc,
                      input string req);
    logic [NCHK-1:0] g;
    logic [1:0]      exp;
    func_out = fo;
    pred_chk = pc;
    g = model_gen(fo);
    @(negedge clk);
    if (g != pc) begin
      note(ind == 2'b00 || ind == 2'b11, req, ind, "00 or 11");
    end else begin
      exp = (^g) ? 2'b01 : 2'b10;
      note(ind == exp, req, ind, $sformatf("%b", exp));
    end
  endtask

  initial begin
    logic [NOUT-1:0] base;
    int lit[7] = '{3, 6, 9, 11, 13, 15, 5};
    build_rows();
    rst = 1'b1;
    func_out = '0;
    pred_chk = '0;
    repeat (3) @(negedge clk);
    // R1: reset value
    note(ind == 2'b01, "R1 reset value", ind, "01");
    func_out = 7'h55;
    pred_chk = 4'h0;
    @(negedge clk);
    note(ind == 2'b01, "R1 mismatch ignored in reset", ind, "01");
    rst = 1'b0;

    // R4/R9: fault-free words
    step('0, '0, "R9 zero word");
    for (int t = 0; t < 40; t++) begin
      base = NOUT'($urandom);
      step(base, model_gen(base), "R4 R9 fault-free");
    end

    // R2: no combinational path, then update after one edge
    base = 7'h2B;
    step(base, model_gen(base), "R2 setup");
    func_out = base ^ 7'h01;
    #2;
    note(ind == ((^model_gen(base)) ? 2'b01 : 2'b10), "R2 held before edge", ind,
         "previous code word");
    @(negedge clk);
    note(ind == 2'b00 || ind == 2'b11, "R2 updated after edge", ind, "00 or 11");
    base = 7'h2B;
    step(base, model_gen(base), "R2 back to clean");
    step(base, model_gen(base), "R2 held inputs");

    // R3: literal rows; flipping output i with pred adjusted by its row stays clean
    for (int i = 0; i < NOUT; i++) begin
      base = NOUT'($urandom);
      step(base ^ NOUT'(1 << i), model_gen(base) ^ NCHK'(lit[i]), "R3 row value");
    end

    // R6: single output flips
    for (int i = 0; i < NOUT; i++) begin
      base = NOUT'($urandom);
      step(base, model_gen(base), "R6 clean before flip");
      step(base ^ NOUT'(1 << i), model_gen(base), "R6 single output flip");
    end

    // R7: single predicted-bit flips
    for (int k = 0; k < NCHK; k++) begin
      base = NOUT'($urandom);
      step(base, model_gen(base), "R7 clean before flip");
      step(base, model_gen(base) ^ NCHK'(1 << k), "R7 single check flip");
    end

    // R8: every pair of output flips
    for (int i = 0; i < NOUT; i++)
      for (int j = i + 1; j < NOUT; j++) begin
        base = NOUT'($urandom);
        step(base ^ NOUT'(1 << i) ^ NOUT'(1 << j), model_gen(base),
             "R8 double output flip");
      end

    // R5: random multi-bit flips on both sides
    for (int t = 0; t < 60; t++) begin
      base = NOUT'($urandom);
      step(base ^ NOUT'($urandom), model_gen(base) ^ NCHK'($urandom),
           "R5 R4 multi-bit flip");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2: watchdog expired, ind=%b expected run to finish", ind);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule